// File: doc/BRIEF.md
# Hamming Sector Single-Bit Corrector

This block repairs one 512-byte sector after it has been read back from flash. It is given two 24-bit Hamming codes: the one stored next to the sector and the one computed again from the data that came back. It combines the two into a syndrome and decides between three results. The data may be clean. One bit may be wrong and fixable. Or the damage may be beyond repair.

When a single bit is wrong, the block works out which byte and which bit within that byte hold the error. It then inverts that bit in the sector buffer by reading the byte once and writing it back once. A pulse on `start` begins a job. A one-cycle `done` pulse ends it. The three status flags and the reported location stay valid until the next job is accepted.

The sector buffer is outside the block. It has a registered read: data requested in one cycle appears on `buf_rdata` in the next cycle.

Top module: `hamming_sector_fixer`

## Requirements
- R1: The syndrome is `stored_code ^ calc_code`, taken bit by bit over 24 bits. Code byte 0 sits in bits [7:0], byte 1 in [15:8] and byte 2 in [23:16].
- R2: A zero syndrome sets `no_err`. No buffer access is made, and `done` pulses in the second cycle after the edge that accepts `start`.
- R3: The syndrome is read as twelve 2-bit pairs, starting at bit 0. A pair equal to 2'b10 gives a 1. A pair equal to 2'b01 gives a 0. A pair equal to 2'b00 or 2'b11, in any of the twelve positions, makes a nonzero syndrome uncorrectable.
- R4: Pairs 0 to 2 (syndrome bits [5:0]) form `err_bit`, with pair 0 as its least significant bit.
- R5: Pairs 3 to 11 (syndrome bits [23:6]) form `err_byte`, with pair 3 as its least significant bit.
- R6: For a correctable syndrome, the block reads byte `err_byte` of the buffer. It writes that byte back exactly once, with only bit `err_bit` inverted. It then sets `corrected`, which means one bit was repaired.
- R7: For an uncorrectable syndrome, the block sets `uncorrectable` and does not write the buffer. `done` pulses in the second cycle after the edge that accepts `start`.
- R8: `done` is high for exactly one cycle per job. For a correction, `done` comes in the fourth cycle after the edge that accepts `start`, one cycle after the write.
- R9: `start` is ignored while `busy` is high, including the cycle in which `done` is high. Status outputs are cleared only when a new job is accepted.
- R10: After reset, `busy`, `done`, the three status flags and all buffer strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; sampled only while idle |
| stored_code | input | 24 | Hamming code stored with the sector |
| calc_code | input | 24 | Hamming code computed again from the data read back |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| no_err | output | 1 | The syndrome was zero |
| corrected | output | 1 | One bit was repaired |
| uncorrectable | output | 1 | The syndrome cannot be decoded to a single bit |
| err_byte | output | 9 | Byte address of the bit in error |
| err_bit | output | 3 | Position of the bit in error within the byte |
| buf_addr | output | 9 | Sector buffer address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after `buf_rd_en` |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |

## Verification
Two events can fall in the same cycle: a job finishing and a new request arriving. The bench holds `start` high, with different codes on the inputs, through a whole correction, including the cycle in which `done` is high. It then checks three things: exactly one `done` pulse and exactly one buffer write occurred, the status reflects the first pair of codes, and no second job begins. Random and directed syndromes cover the boundaries of the pair decode: byte 0 bit 0, byte 511 bit 7, a bad pair in the top position and a bad pair in the bit-position field. After every job, each byte of the bench's buffer model is compared with a shadow copy.

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer #(
  parameter int CODE_W = 24,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CODE_W-1:0]    stored_code,
  input  logic [CODE_W-1:0]    calc_code,
  output logic                 busy,
  output logic                 done,
  output logic                 no_err,
  output logic                 corrected,
  output logic                 uncorrectable,
  output logic [8:0]           err_byte,
  output logic [2:0]           err_bit,
  output logic [8:0]           buf_addr,
  output logic                 buf_rd_en,
  input  logic [DATA_W-1:0]    buf_rdata,
  output logic                 buf_wr_en,
  output logic [DATA_W-1:0]    buf_wdata
);
  localparam int NPAIR = CODE_W / 2;
  localparam int BITW  = 3;
  localparam int BYTEW = NPAIR - BITW;

  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_RD, S_WR, S_FIN} st_t;
  st_t st;

  logic [CODE_W-1:0] syn_q;
  logic [NPAIR-1:0]  code;
  logic              bad;

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < NPAIR; i++) begin
      code[i] = syn_q[2*i+1];
      if (syn_q[2*i+1] == syn_q[2*i]) bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      syn_q         <= '0;
      no_err        <= 1'b0;
      corrected     <= 1'b0;
      uncorrectable <= 1'b0;
      err_byte      <= '0;
      err_bit       <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          syn_q         <= stored_code ^ calc_code;
          no_err        <= 1'b0;
          corrected     <= 1'b0;
          uncorrectable <= 1'b0;
          st            <= S_DECIDE;
        end
        S_DECIDE: begin
          if (syn_q == '0) begin
            no_err <= 1'b1;
            st     <= S_FIN;
          end else if (bad) begin
            uncorrectable <= 1'b1;
            st            <= S_FIN;
          end else begin
            corrected <= 1'b1;
            err_bit   <= code[BITW-1:0];
            err_byte  <= code[NPAIR-1:BITW];
            st        <= S_RD;
          end
        end
        S_RD:    st <= S_WR;
        S_WR:    st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign buf_addr  = err_byte;
  assign buf_rd_en = (st == S_RD);
  assign buf_wr_en = (st == S_WR);
  assign buf_wdata = buf_rdata ^ (DATA_W'(1) << err_bit);

  if (BYTEW != 9) begin : g_bad_cfg
    initial $display("hamming_sector_fixer: CODE_W must be 24");
  end
endmodule

module hamming_sector_fixer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       no_err,
  input logic       corrected,
  input logic       uncorrectable,
  input logic [8:0] buf_addr,
  input logic       buf_rd_en,
  input logic [7:0] buf_rdata,
  input logic       buf_wr_en,
  input logic [7:0] buf_wdata
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({no_err, corrected, uncorrectable})); // R6
  AST_NO_WR_UNCORR: assert property (@(posedge clk) disable iff (!rst_n) uncorrectable |-> !buf_wr_en); // R7
  AST_NO_ACCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) no_err |-> !buf_wr_en && !buf_rd_en); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) buf_wr_en |-> $past(buf_rd_en) && $stable(buf_addr)); // R6
  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n) buf_wr_en |-> $countones(buf_wdata ^ buf_rdata) == 1); // R6
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) buf_wr_en |=> done); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R9
endmodule

bind hamming_sector_fixer hamming_sector_fixer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .no_err(no_err), .corrected(corrected), .uncorrectable(uncorrectable),
  .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
  .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
);

// File: tb/hamming_sector_fixer_tb.sv
module hamming_sector_fixer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic busy, done, no_err, corrected, uncorrectable, buf_rd_en, buf_wr_en;
  logic [8:0] err_byte, buf_addr;
  logic [2:0] err_bit;
  logic [7:0] buf_rdata, buf_wdata;

  int checks = 0, errors = 0;
  int done_cnt = 0, wr_cnt = 0;
  logic [7:0] mem [512];
  logic [7:0] shadow [512];

  always #5 clk = ~clk;

  hamming_sector_fixer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
    .calc_code(calc_code), .busy(busy), .done(done), .no_err(no_err),
    .corrected(corrected), .uncorrectable(uncorrectable), .err_byte(err_byte),
    .err_bit(err_bit), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
    .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
  );

  always_ff @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    if (done) done_cnt <= done_cnt + 1;
    if (buf_wr_en) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] encode(input int byte_a, input int bit_p);
    logic [23:0] s;
    int v;
    v = byte_a * 8 + bit_p;
    s = '0;
    for (int i = 0; i < 12; i++) s[2*i +: 2] = ((v >> i) & 1) ? 2'b10 : 2'b01;
    return s;
  endfunction

  // expected outcome: 0 clean, 1 corrected, 2 uncorrectable
  function automatic int classify(input logic [23:0] s, output int byte_a, output int bit_p);
    int rest, val, w;
    byte_a = 0; bit_p = 0;
    if (s == 0) return 0;
    rest = int'(s); val = 0; w = 1;
    for (int i = 0; i < 12; i++) begin
      if (rest % 4 == 2) val += w;
      else if (rest % 4 != 1) return 2;
      w *= 2; rest /= 4;
    end
    bit_p = val % 8; byte_a = val / 8;
    return 1;
  endfunction

  task automatic compare_mem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run(input logic [23:0] sc, input logic [23:0] cc);
    int kind, eb, ebit, lat, d0, w0;
    kind = classify(sc ^ cc, eb, ebit);
    d0 = done_cnt; w0 = wr_cnt;
    @(negedge clk);
    stored_code = sc; calc_code = cc; start = 1'b1;
    @(negedge clk);
    start = 1'b0; stored_code = $urandom; calc_code = $urandom;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    if (kind == 0) begin
      chk(lat == 2, "R2 latency", lat, 2);
      chk(no_err && !corrected && !uncorrectable, "R2 status", {no_err, corrected, uncorrectable}, 4);
    end else if (kind == 2) begin
      chk(lat == 2, "R7 latency", lat, 2);
      chk(uncorrectable && !no_err && !corrected, "R3 R7 status", {no_err, corrected, uncorrectable}, 1);
    end else begin
      chk(lat == 4, "R8 latency", lat, 4);
      chk(corrected && !no_err && !uncorrectable, "R6 status", {no_err, corrected, uncorrectable}, 2);
      chk(err_bit == ebit, "R4 err_bit", err_bit, ebit);
      chk(err_byte == eb, "R5 err_byte", err_byte, eb);
      shadow[eb] = shadow[eb] ^ (8'd1 << ebit);
    end
    @(negedge clk);
    chk(!done, "R8 single pulse", done, 0);
    chk(done_cnt == d0 + 1, "R8 done count", done_cnt - d0, 1);
    chk(wr_cnt == w0 + (kind == 1 ? 1 : 0), "R6 R7 write count", wr_cnt - w0, kind == 1);
    compare_mem(kind == 1 ? "R6 buffer" : "R2 R7 buffer untouched");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d0, w0, eb, ebit;
    logic [23:0] sc, s;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++) begin mem[i] = 8'($urandom); shadow[i] = mem[i]; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !no_err && !corrected && !uncorrectable && !buf_rd_en && !buf_wr_en,
        "R10 reset", {busy, done, no_err, corrected, uncorrectable}, 0);
    rst_n = 1'b1;
    // R1: code byte order in syndrome, directed
    sc = 24'h3C_A5_0F;
    run(sc, sc);
    run(sc, sc ^ encode(0, 0));
    run(sc, sc ^ encode(511, 7));
    run(sc, sc ^ 24'h555556);              // R1 R4: byte 0, bit 1
    run(sc, sc ^ (encode(300, 5) | 24'hC00000)); // R3: top pair 11
    run(sc, sc ^ (encode(17, 2) & 24'hFFFFF3));  // R3: pair 1 forced 00
    run(24'hFFFFFF, 24'h000000);           // R3: all pairs 11
    // R9: start held through a correction, including the done cycle
    sc = 24'h123456;
    s = encode(42, 6);
    d0 = done_cnt; w0 = wr_cnt;
    @(negedge clk);
    stored_code = sc; calc_code = sc ^ s; start = 1'b1;
    @(negedge clk);
    stored_code = 24'h0; calc_code = 24'hFFFFFF;
    while (!done) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    shadow[42] = shadow[42] ^ 8'h40;
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 one job", done_cnt - d0, 1);
    chk(wr_cnt == w0 + 1, "R9 one write", wr_cnt - w0, 1);
    chk(corrected && err_byte == 42 && err_bit == 6, "R9 status kept", err_byte, 42);
    chk(!busy, "R9 no new job", busy, 0);
    compare_mem("R9 buffer");
    // random mix
    for (int n = 0; n < 300; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      sc = 24'($urandom);
      if (sel == 0) s = '0;
      else if (sel == 3) s = 24'($urandom);
      else s = encode($urandom_range(0, 511), $urandom_range(0, 7));
      void'(classify(s, eb, ebit));
      run(sc, sc ^ s);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule